// File: doc/BRIEF.md
# Barrel Shifter with Carry-Out

This block is the operand shifter of a 32-bit RISC datapath. It takes a data word, a three-bit shift-kind code, a shift amount and the current carry flag. In the same cycle it returns the shifted word and the carry that the shift would produce. It has no registers. The kinds are logical left, logical right, arithmetic right, rotate right, and a one-place rotate right that passes through the carry flag. The block only reports the carry. The surrounding pipeline decides whether to commit it to the flags.

Internally a control decoder turns the kind code and the amount into a small bundle of strobes. The strobes select a result source, select a carry source, and give the rotate and mask amounts. The datapath uses a single logarithmic rotator for every kind. A mask generator then clears or fills the bit positions that were vacated. Amounts of zero, exactly the word width, and above the word width each go down their own decoded path. Each gives the result and carry its kind requires at that boundary.

Top module: `barrel_shift_carry`

## Requirements
- R1: Kind code 0 is logical left, 1 logical right, 2 arithmetic right, 3 rotate right and 4 rotate right extended; codes 5, 6 and 7 return the operand unchanged with carry-out equal to carry-in.
- R2: Only bits 7:0 of the shift amount are used; any value in the higher bits has no effect on result or carry.
- R3: For kinds 0 to 3, an amount of zero returns the operand unchanged and carry-out equals carry-in.
- R4: Logical left by 1 to 31 gives the operand shifted left with zeros in, carry-out = operand bit (32 − amount); by exactly 32 gives result 0 and carry-out = operand bit 0.
- R5: Logical right by 1 to 31 gives the operand shifted right with zeros in, carry-out = operand bit (amount − 1); by exactly 32 gives result 0 and carry-out = operand bit 31.
- R6: A logical shift, left or right, by 33 to 255 gives result 0 and carry-out 0.
- R7: Arithmetic right by 1 to 31 fills vacated bits with operand bit 31, carry-out = operand bit (amount − 1); by 32 to 255 every result bit and the carry-out equal operand bit 31.
- R8: Rotate right by a non-zero amount rotates by the amount modulo 32 and carry-out equals result bit 31; a non-zero multiple of 32 returns the operand with carry-out = operand bit 31.
- R9: Rotate right extended returns {carry-in, operand[31:1]} with carry-out = operand bit 0, whatever the amount.
- R10: Result and carry-out depend only on the current inputs, with no storage, so they are valid in the cycle the inputs are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opIn | input | 32 | Operand word to be shifted |
| shiftKind | input | 3 | Shift-kind code (see R1) |
| shiftAmt | input | 32 | Shift amount; only bits 7:0 take effect |
| carryIn | input | 1 | Current carry flag |
| resultOut | output | 32 | Shifted word |
| carryOut | output | 1 | Shifter carry-out |

## Verification
Both results are due zero cycles after a stimulus, because no register lies between any input and either output. The bench applies every input set just after a falling clock edge. It compares the outputs one time unit later, still inside the same low phase, so no comparison straddles an active edge. The bench walks every kind code across amounts at all boundaries (0, 1, 31, 32, 33, multiples of 32, 255, and values with high bits set), with both carry-in values and several operand patterns. It compares each case against an arithmetic model of the requirements.

// File: rtl/barrel_shift_pkg.sv
package barrel_shift_pkg;

  typedef enum logic [2:0] {
    KIND_LSL = 3'd0,
    KIND_LSR = 3'd1,
    KIND_ASR = 3'd2,
    KIND_ROR = 3'd3,
    KIND_RRX = 3'd4
  } shiftKind_e;

  typedef enum logic [2:0] {
    RES_PASS,
    RES_ZERO,
    RES_SIGN,
    RES_MASK,
    RES_FILL,
    RES_ROT,
    RES_EXTEND
  } resSel_e;

  typedef enum logic [2:0] {
    CY_IN,
    CY_ZERO,
    CY_ROTHI,
    CY_ROTLO,
    CY_XLO,
    CY_XHI
  } carrySel_e;

  typedef struct packed {
    resSel_e   resSel;
    carrySel_e carrySel;
    logic      maskLeft;
  } shiftStrobe_t;

endpackage

// File: rtl/shift_rotator.sv
module shift_rotator #(
  parameter int W     = 32,
  parameter int LOG2W = $clog2(W)
) (
  input  logic [W-1:0]     dataIn,
  input  logic [LOG2W-1:0] rotAmt,
  output logic [W-1:0]     dataOut
);

  logic [W-1:0] stage [LOG2W+1];

  assign stage[0] = dataIn;

  for (genvar k = 0; k < LOG2W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stage[k+1] = rotAmt[k]
      ? {stage[k][STEP-1:0], stage[k][W-1:STEP]}
      : stage[k];
  end

  assign dataOut = stage[LOG2W];

endmodule

// File: rtl/shift_control.sv
module shift_control
  import barrel_shift_pkg::*;
#(
  parameter int W        = 32,
  parameter int AMT_USED = 8,
  parameter int LOG2W    = $clog2(W)
) (
  input  logic [2:0]          shiftKind,
  input  logic [AMT_USED-1:0] amtLow,
  output shiftStrobe_t        strobe,
  output logic [LOG2W-1:0]    rotAmt,
  output logic [LOG2W-1:0]    maskAmt
);

  localparam logic [AMT_USED:0] FULL_AMT = (AMT_USED+1)'(W);

  logic             isZero;
  logic             isFull;
  logic             isOver;
  logic [LOG2W-1:0] rotLow;
  logic [LOG2W-1:0] negLow;
  shiftKind_e       kind;

  assign kind   = shiftKind_e'(shiftKind);
  assign isZero = (amtLow == '0);
  assign isFull = ({1'b0, amtLow} == FULL_AMT);
  assign isOver = ({1'b0, amtLow} > FULL_AMT);
  assign rotLow = amtLow[LOG2W-1:0];
  assign negLow = LOG2W'(0) - rotLow;
  assign maskAmt = rotLow;

  always_comb begin
    strobe.resSel   = RES_PASS;
    strobe.carrySel = CY_IN;
    strobe.maskLeft = 1'b0;
    rotAmt          = '0;
    if (kind == KIND_RRX) begin
      strobe.resSel   = RES_EXTEND;
      strobe.carrySel = CY_XLO;
    end else if (!isZero) begin
      case (kind)
        KIND_LSL: begin
          if (isOver) begin
            strobe.resSel   = RES_ZERO;
            strobe.carrySel = CY_ZERO;
          end else if (isFull) begin
            strobe.resSel   = RES_ZERO;
            strobe.carrySel = CY_XLO;
          end else begin
            strobe.resSel   = RES_MASK;
            strobe.carrySel = CY_ROTLO;
            strobe.maskLeft = 1'b1;
            rotAmt          = negLow;
          end
        end
        KIND_LSR: begin
          if (isOver) begin
            strobe.resSel   = RES_ZERO;
            strobe.carrySel = CY_ZERO;
          end else if (isFull) begin
            strobe.resSel   = RES_ZERO;
            strobe.carrySel = CY_XHI;
          end else begin
            strobe.resSel   = RES_MASK;
            strobe.carrySel = CY_ROTHI;
            rotAmt          = rotLow;
          end
        end
        KIND_ASR: begin
          if (isOver || isFull) begin
            strobe.resSel   = RES_SIGN;
            strobe.carrySel = CY_XHI;
          end else begin
            strobe.resSel   = RES_FILL;
            strobe.carrySel = CY_ROTHI;
            rotAmt          = rotLow;
          end
        end
        KIND_ROR: begin
          strobe.resSel   = RES_ROT;
          strobe.carrySel = CY_ROTHI;
          rotAmt          = rotLow;
        end
        default: begin
          strobe.resSel   = RES_PASS;
          strobe.carrySel = CY_IN;
        end
      endcase
    end
  end

  // R6
  always_comb begin
    if ((kind == KIND_LSL || kind == KIND_LSR) && isOver) begin
      logical_over_zero_chk: assert (strobe.carrySel == CY_ZERO && strobe.resSel == RES_ZERO)
        else $error("R6 logical shift beyond width not cleared");
    end
  end

endmodule

// File: rtl/shift_datapath.sv
module shift_datapath
  import barrel_shift_pkg::*;
#(
  parameter int W     = 32,
  parameter int LOG2W = $clog2(W)
) (
  input  logic [W-1:0]     opIn,
  input  logic             carryIn,
  input  shiftStrobe_t     strobe,
  input  logic [LOG2W-1:0] rotAmt,
  input  logic [LOG2W-1:0] maskAmt,
  output logic [W-1:0]     resultOut,
  output logic             carryOut
);

  localparam logic [W-1:0] ALL_ONES = '1;

  logic [W-1:0] rotated;
  logic [W-1:0] keepMask;
  logic         signBit;

  shift_rotator #(.W(W), .LOG2W(LOG2W)) u_rot (
    .dataIn (opIn),
    .rotAmt (rotAmt),
    .dataOut(rotated)
  );

  assign signBit  = opIn[W-1];
  assign keepMask = strobe.maskLeft ? (ALL_ONES << maskAmt) : (ALL_ONES >> maskAmt);

  always_comb begin
    case (strobe.resSel)
      RES_ZERO:   resultOut = '0;
      RES_SIGN:   resultOut = {W{signBit}};
      RES_MASK:   resultOut = rotated & keepMask;
      RES_FILL:   resultOut = (rotated & keepMask) | ({W{signBit}} & ~keepMask);
      RES_ROT:    resultOut = rotated;
      RES_EXTEND: resultOut = {carryIn, opIn[W-1:1]};
      default:    resultOut = opIn;
    endcase
  end

  always_comb begin
    case (strobe.carrySel)
      CY_ZERO:  carryOut = 1'b0;
      CY_ROTHI: carryOut = rotated[W-1];
      CY_ROTLO: carryOut = rotated[0];
      CY_XLO:   carryOut = opIn[0];
      CY_XHI:   carryOut = opIn[W-1];
      default:  carryOut = carryIn;
    endcase
  end

  // R5
  always_comb begin
    if (strobe.resSel == RES_MASK && !strobe.maskLeft) begin
      right_top_clear_chk: assert (resultOut[W-1] == 1'b0)
        else $error("R5 logical right left a set top bit");
    end
  end

  // R4
  always_comb begin
    if (strobe.resSel == RES_MASK && strobe.maskLeft) begin
      left_low_clear_chk: assert (resultOut[0] == 1'b0)
        else $error("R4 logical left left a set low bit");
    end
  end

endmodule

// File: rtl/barrel_shift_carry.sv
module barrel_shift_carry
  import barrel_shift_pkg::*;
#(
  parameter int W        = 32,
  parameter int AMT_IN_W = 32,
  parameter int AMT_USED = 8
) (
  input  logic [W-1:0]        opIn,
  input  logic [2:0]          shiftKind,
  input  logic [AMT_IN_W-1:0] shiftAmt,
  input  logic                carryIn,
  output logic [W-1:0]        resultOut,
  output logic                carryOut
);

  localparam int LOG2W = $clog2(W);

  shiftStrobe_t     strobe;
  logic [LOG2W-1:0] rotAmt;
  logic [LOG2W-1:0] maskAmt;
  logic [AMT_USED-1:0] amtLow;

  assign amtLow = shiftAmt[AMT_USED-1:0];

  shift_control #(.W(W), .AMT_USED(AMT_USED), .LOG2W(LOG2W)) u_ctrl (
    .shiftKind(shiftKind),
    .amtLow   (amtLow),
    .strobe   (strobe),
    .rotAmt   (rotAmt),
    .maskAmt  (maskAmt)
  );

  shift_datapath #(.W(W), .LOG2W(LOG2W)) u_dp (
    .opIn     (opIn),
    .carryIn  (carryIn),
    .strobe   (strobe),
    .rotAmt   (rotAmt),
    .maskAmt  (maskAmt),
    .resultOut(resultOut),
    .carryOut (carryOut)
  );

  // R3
  always_comb begin
    if (amtLow == '0 && shiftKind < 3'd4) begin
      zero_amount_pass_chk: assert (resultOut == opIn && carryOut == carryIn)
        else $error("R3 zero amount altered operand or carry");
    end
  end

  // R2
  always_comb begin
    if (shiftAmt != '0 && amtLow == '0 && shiftKind == 3'd1) begin
      high_bits_ignored_chk: assert (resultOut == opIn)
        else $error("R2 upper amount bits took effect");
    end
  end

  // R7
  always_comb begin
    if (shiftKind == 3'd2 && amtLow >= AMT_USED'(W)) begin
      asr_saturate_chk: assert (resultOut == {W{opIn[W-1]}} && carryOut == opIn[W-1])
        else $error("R7 wide arithmetic shift not sign filled");
    end
  end

  // R8
  always_comb begin
    if (shiftKind == 3'd3 && amtLow != '0) begin
      rotate_carry_chk: assert (carryOut == resultOut[W-1])
        else $error("R8 rotate carry differs from result top bit");
    end
  end

  // R9
  always_comb begin
    if (shiftKind == 3'd4) begin
      extend_chk: assert (resultOut[W-1] == carryIn && carryOut == opIn[0])
        else $error("R9 extended rotate mismatch");
    end
  end

  // R1
  always_comb begin
    if (shiftKind > 3'd4) begin
      unused_kind_chk: assert (resultOut == opIn && carryOut == carryIn)
        else $error("R1 reserved kind code altered data");
    end
  end

endmodule

// File: tb/barrel_shift_carry_tb.sv
module barrel_shift_carry_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] opIn = '0;
  logic [2:0]  shiftKind = '0;
  logic [31:0] shiftAmt = '0;
  logic        carryIn = 1'b0;
  logic [31:0] resultOut;
  logic        carryOut;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  barrel_shift_carry u_dut (
    .opIn     (opIn),
    .shiftKind(shiftKind),
    .shiftAmt (shiftAmt),
    .carryIn  (carryIn),
    .resultOut(resultOut),
    .carryOut (carryOut)
  );

  function automatic void model(input logic [31:0] x, input logic [2:0] k,
                                input logic [31:0] raw, input logic cin,
                                output logic [31:0] r, output logic c);
    int a;
    int m;
    a = int'(raw & 32'hFF);
    r = x;
    c = cin;
    case (k)
      3'd0: if (a != 0) begin
        if (a < 32)       begin r = x << a; c = x[32-a]; end
        else if (a == 32) begin r = '0; c = x[0]; end
        else              begin r = '0; c = 1'b0; end
      end
      3'd1: if (a != 0) begin
        if (a < 32)       begin r = x >> a; c = x[a-1]; end
        else if (a == 32) begin r = '0; c = x[31]; end
        else              begin r = '0; c = 1'b0; end
      end
      3'd2: if (a != 0) begin
        if (a < 32) begin r = $unsigned($signed(x) >>> a); c = x[a-1]; end
        else        begin r = {32{x[31]}}; c = x[31]; end
      end
      3'd3: if (a != 0) begin
        m = a % 32;
        r = (m == 0) ? x : ((x >> m) | (x << (32 - m)));
        c = r[31];
      end
      3'd4: begin r = {cin, x[31:1]}; c = x[0]; end
      default: begin r = x; c = cin; end
    endcase
  endfunction

  function automatic string reqTag(input logic [2:0] k, input logic [31:0] raw);
    int a;
    a = int'(raw & 32'hFF);
    if (k > 3'd4)       return "R1";
    if (k == 3'd4)      return "R9";
    if (raw > 32'd255)  return "R2";
    if (a == 0)         return "R3";
    if (k == 3'd0)      return (a <= 32) ? "R4" : "R6";
    if (k == 3'd1)      return (a <= 32) ? "R5" : "R6";
    if (k == 3'd2)      return "R7";
    return "R8";
  endfunction

  task automatic checkOne(input logic [31:0] x, input logic [2:0] k,
                          input logic [31:0] raw, input logic cin);
    logic [31:0] expR;
    logic        expC;
    @(negedge clk);
    opIn = x; shiftKind = k; shiftAmt = raw; carryIn = cin;
    #1;
    model(x, k, raw, cin, expR, expC);
    checks++;
    if (resultOut !== expR || carryOut !== expC) begin
      errors++;
      $display("FAIL %s kind=%0d amt=%h op=%h cin=%b: got res=%h c=%b, want res=%h c=%b",
               reqTag(k, raw), k, raw, x, cin, resultOut, carryOut, expR, expC);
    end
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired: got running, want finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stimulus
    logic [31:0] amts [15];
    logic [31:0] ops [6];
    amts = '{32'd0, 32'd1, 32'd2, 32'd7, 32'd16, 32'd31, 32'd32, 32'd33,
             32'd63, 32'd64, 32'd96, 32'd255, 32'd256, 32'd257, 32'h1000_0020};
    ops  = '{32'h8000_0001, 32'h7FFF_FFFE, 32'hDEAD_BEEF,
             32'h1234_5678, 32'hFFFF_FFFF, 32'h0000_0000};
    repeat (3) @(posedge clk);
    // R10: all-zero inputs give zero result and zero carry with no clock dependency
    @(negedge clk);
    #1;
    checks++;
    if (resultOut !== 32'h0 || carryOut !== 1'b0) begin
      errors++;
      $display("FAIL R10 reset-time outputs: got res=%h c=%b, want res=00000000 c=0",
               resultOut, carryOut);
    end
    rstN = 1'b1;
    for (int k = 0; k < 8; k++) begin
      for (int ai = 0; ai < 15; ai++) begin
        for (int ci = 0; ci < 2; ci++) begin
          for (int oi = 0; oi < 6; oi++) begin
            checkOne(ops[oi], 3'(k), amts[ai], ci[0]);
          end
        end
      end
    end
    // R2: high bits with otherwise identical low byte, left shift by 4
    checkOne(32'hA5A5_0F0F, 3'd0, 32'hFFFF_FF04, 1'b1);
    // R9: extended rotate ignores a large amount
    checkOne(32'h0000_0003, 3'd4, 32'h0000_00FF, 1'b0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule